// File: doc/BRIEF.md
# Eight-Way Time-Slot Memory Arbiter With Idle-Slot Reclaim

The block decides, every cycle, which of eight cores may use one shared memory port. A free-running slot counter walks through the cores in order, so each core owns exactly one cycle in every eight. The owner of the current slot always gets the port when it asks for it. When the owner stays silent, the slot is idle. It can then go to another requesting core, but only to one that has its reclaim-enable input set.

When several enabled cores compete for an idle slot, a round-robin pointer settles the contest. The search starts at the pointer, and after each award the pointer moves to the core just past the winner. A core whose reclaim-enable is low is served exactly as in a plain one-in-eight rotation. A core that enables reclaim is still promised only its own slot; anything more is best-effort. For checking fairness, a per-core counter records how many reclaimed slots each core has received.

Top module: `tslot_arbiter`

## Requirements
- R1: At most one bit of `grant` is high in any cycle. `grant` bit i means core i uses the port in that cycle.
- R2: `slot` is 0 in the first cycle after reset and advances by one each cycle, wrapping from 7 to 0. Core `slot` owns that cycle.
- R3: If the owning core's `req` bit is high, `grant` is exactly that core's bit, whatever `spare_en` holds.
- R4: A non-owner may receive `grant` only if its `req` bit and its `spare_en` bit are both high, and only while the owner's `req` is low.
- R5: If the owner is idle and at least one other core has both `req` and `spare_en` high, exactly one such core is granted. If no core qualifies, `grant` is all zero.
- R6: Idle slots are awarded in round-robin order. The search starts at a pointer, which is 0 after reset, and proceeds upward with wrap. After each award the pointer becomes the winner's index plus one, modulo 8. Slots used by their owners leave the pointer unchanged.
- R7: With every `spare_en` bit low, the grant pattern is the plain rotation: core i is granted exactly in the cycles where `slot` equals i and `req[i]` is high.
- R8: `spare_cnt` field i (bits 16*i+15 down to 16*i) counts the idle slots awarded to core i since reset. All fields are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 8 | Per-core access request |
| spare_en | input | 8 | Per-core idle-slot reclaim enable |
| grant | output | 8 | One-hot or zero port grant, same cycle as request |
| slot | output | 3 | Index of the core that owns the current cycle |
| spare_cnt | output | 128 | Eight 16-bit counts of reclaimed slots received |

## Verification
A slot counter that is out of step shows at once, in the same cycle, as a grant going to the wrong owner. It also shows directly on `slot`. A round-robin pointer in the wrong state does not show until the next contested idle slot. At that point a different enabled core wins, and the wrong winner appears in `grant` and later in the `spare_cnt` totals. A tally that drifts shows only in `spare_cnt`, so the bench compares every field after a mixed sequence.

// File: rtl/tslot_arb_pkg.sv
package tslot_arb_pkg;
  localparam int unsigned CORES = 8;
  localparam int unsigned IDX_W = $clog2(CORES);

  // next index around the ring
  function automatic logic [IDX_W-1:0] ring_next(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(CORES - 1)) ? '0 : i + 1'b1;
  endfunction

  // first set bit of vec at or after start, searching upward with wrap
  function automatic logic [IDX_W:0] ring_first(input logic [CORES-1:0] vec,
                                                input logic [IDX_W-1:0] start);
    logic [IDX_W:0] res;
    logic [IDX_W-1:0] idx;
    res = '0;
    idx = start;
    for (int k = 0; k < CORES; k++) begin
      if (!res[IDX_W] && vec[idx]) res = {1'b1, idx};
      idx = ring_next(idx);
    end
    return res;  // MSB = found, low bits = index
  endfunction
endpackage

// File: rtl/tslot_ring.sv
module tslot_ring
  import tslot_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] slot_q,
  output logic [CORES-1:0] owner_oh
);
  always_ff @(posedge clk) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= ring_next(slot_q);
  end

  always_comb begin
    owner_oh = '0;
    owner_oh[slot_q] = 1'b1;
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  a_r2_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> slot_q == ring_next($past(slot_q)));
endmodule

// File: rtl/tslot_spare_pick.sv
module tslot_spare_pick
  import tslot_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CORES-1:0] cand,      // enabled, requesting non-owners
  input  logic             open_slot, // owner idle this cycle
  output logic [CORES-1:0] pick_oh,
  output logic             award
);
  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W:0]   hit;

  always_comb begin
    hit     = ring_first(cand, rr_ptr);
    award   = open_slot && hit[IDX_W];
    pick_oh = '0;
    if (award) pick_oh[hit[IDX_W-1:0]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rr_ptr <= '0;
    else if (award) rr_ptr <= ring_next(hit[IDX_W-1:0]);
  end

  a_r5_award_when_cand: assert property (@(posedge clk) disable iff (!rst_n)
    (open_slot && cand != '0) |-> $onehot(pick_oh));
endmodule

// File: rtl/tslot_spare_tally.sv
module tslot_spare_tally
  import tslot_arb_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CORES-1:0]       bump,
  output logic [CORES*CNT_W-1:0] counts
);
  for (genvar g = 0; g < CORES; g++) begin : g_cnt
    logic [CNT_W-1:0] c_q;
    always_ff @(posedge clk) begin
      if (!rst_n)      c_q <= '0;
      else if (bump[g]) c_q <= c_q + 1'b1;
    end
    assign counts[g*CNT_W +: CNT_W] = c_q;
  end
endmodule

// File: rtl/tslot_arbiter.sv
module tslot_arbiter
  import tslot_arb_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CORES-1:0]       req,
  input  logic [CORES-1:0]       spare_en,
  output logic [CORES-1:0]       grant,
  output logic [IDX_W-1:0]       slot,
  output logic [CORES*CNT_W-1:0] spare_cnt
);
  logic [CORES-1:0] owner_oh;
  logic [CORES-1:0] cand;
  logic [CORES-1:0] pick_oh;
  logic             owner_busy;
  logic             award;

  tslot_ring i_ring (
    .clk(clk), .rst_n(rst_n), .slot_q(slot), .owner_oh(owner_oh)
  );

  assign owner_busy = |(req & owner_oh);
  assign cand       = req & spare_en & ~owner_oh;

  tslot_spare_pick i_pick (
    .clk(clk), .rst_n(rst_n), .cand(cand), .open_slot(!owner_busy),
    .pick_oh(pick_oh), .award(award)
  );

  assign grant = owner_busy ? owner_oh : pick_oh;

  tslot_spare_tally #(.CNT_W(CNT_W)) i_tally (
    .clk(clk), .rst_n(rst_n), .bump(pick_oh), .counts(spare_cnt)
  );

  a_r1_grant_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r3_owner_wins: assert property (@(posedge clk) disable iff (!rst_n)
    req[slot] |-> grant[slot] && $countones(grant) == 1);
  a_r4_reclaim_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !grant[slot]) |-> (!req[slot] && (grant & ~(req & spare_en)) == '0));
  a_r7_plain_rotation: assert property (@(posedge clk) disable iff (!rst_n)
    (spare_en == '0) |-> (grant & ~owner_oh) == '0);
endmodule

// File: tb/test_tslot_arbiter.sv
module test_tslot_arbiter;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   req = '0;
  logic [7:0]   spare_en = '0;
  logic [7:0]   grant;
  logic [2:0]   slot;
  logic [127:0] spare_cnt;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tslot_arbiter i_tslot_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .spare_en(spare_en),
    .grant(grant), .slot(slot), .spare_cnt(spare_cnt)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {req, spare_en, expected grant}, one entry per cycle from slot 0 after reset
  localparam logic [23:0] VEC [16] = '{
    {8'h01, 8'h00, 8'h01},  // R3 owner 0
    {8'h01, 8'h01, 8'h01},  // R5 reclaim by core0, ptr->1
    {8'h05, 8'h01, 8'h04},  // R3 owner 2 wins over enabled core0
    {8'h00, 8'h00, 8'h00},  // R5 nobody
    {8'h0A, 8'h00, 8'h00},  // R4 requesters not enabled
    {8'h0A, 8'h0A, 8'h02},  // R6 ptr1 -> core1, ptr->2
    {8'h0A, 8'h0A, 8'h08},  // R6 ptr2 -> core3, ptr->4
    {8'h0A, 8'h0A, 8'h02},  // R6 ptr4 wraps -> core1, ptr->2
    {8'h8A, 8'hFF, 8'h08},  // R6 ptr2 -> core3, ptr->4
    {8'h8A, 8'hFF, 8'h02},  // R3 owner1, ptr unchanged
    {8'h88, 8'hFF, 8'h80},  // R6 ptr4 -> core7, ptr->0
    {8'h88, 8'hFF, 8'h08},  // R3 owner3
    {8'h80, 8'h7F, 8'h00},  // R4 core7 not enabled
    {8'hFF, 8'hFF, 8'h20},  // R3 owner5 under full contention
    {8'h41, 8'h01, 8'h40},  // R3 owner6
    {8'h01, 8'h01, 8'h01}   // R6 ptr0 -> core0, ptr->1
  };

  initial begin : watchdog
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R2 reset slot", 128'(slot), 128'd0);
    check("R8 reset counts", spare_cnt, '0);

    for (int v = 0; v < 16; v++) begin
      req = VEC[v][23:16];
      spare_en = VEC[v][15:8];
      #1;
      check($sformatf("R2 slot step %0d", v), 128'(slot), 128'(v % 8));
      check($sformatf("R1/R3-R6 grant step %0d", v), 128'(grant), 128'(VEC[v][7:0]));
      @(negedge clk);
    end
    req = '0; spare_en = '0;
    #1;
    // R8 tallies: core0 2, core1 2, core3 2, core7 1
    check("R8 cnt core0", 128'(spare_cnt[15:0]), 128'd2);
    check("R8 cnt core1", 128'(spare_cnt[31:16]), 128'd2);
    check("R8 cnt core2", 128'(spare_cnt[47:32]), 128'd0);
    check("R8 cnt core3", 128'(spare_cnt[63:48]), 128'd2);
    check("R8 cnt core7", 128'(spare_cnt[127:112]), 128'd1);

    // reset mid-run: pointer back to 0
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R8 counts cleared", spare_cnt, '0);
    req = 8'h84; spare_en = 8'hFF;
    #1;
    check("R6 pointer 0 after reset", 128'(grant), 128'h04);
    @(negedge clk);

    // R7 plain rotation: all request, none enabled
    req = 8'hFF; spare_en = 8'h00;
    for (int k = 0; k < 8; k++) begin
      #1;
      check($sformatf("R7 rotation slot %0d", slot), 128'(grant), 128'(8'h01 << slot));
      @(negedge clk);
    end
    // R7 single core, no reclaim: only its own slot
    req = 8'h10;
    for (int k = 0; k < 8; k++) begin
      #1;
      check("R7 single core", 128'(grant), (slot == 3'd4) ? 128'h10 : 128'h0);
      @(negedge clk);
    end
    // R2 wrap check
    #1;
    check("R2 wrap", 128'(slot), 128'd1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule